// File: doc/BRIEF.md
# Second-Order One-Bit Delta-Sigma Modulator

This block is a fixed-point digital model of a second-order delta-sigma loop. The loop has two cascaded delaying integrators and a two-level quantizer. The quantizer decision is fed back to the inputs of both integrators. The input sample reaches the first integrator, the second integrator and the quantizer summing point, each through its own gain. The coupling from the first integrator to the second and the tap from the second integrator to the quantizer also have their own gains. There is no resonator path, so the noise transfer has a double zero at DC. All gains are parameters in signed Q14.

The modulator advances by one sample on each cycle with the enable high and emits one bit per advance. It is used as a bit-exact golden model or as a digital stimulus source for a decimation chain. The quantizer input and both integrator states are brought out for observation. The states saturate at a symmetric bound instead of wrapping. A sticky flag records that clipping has happened.

Number formats:
- The input is Q1.15, so -32768 is -1.0.
- States and the quantizer input use 16 fractional bits, so 65536 is 1.0.

Top module: `sdm2_modulator`

## Requirements
- R1: On a cycle with `en` high and `rst` low, `bitOut` takes the value 1 at the next edge when the signed `quantIn` of that cycle is zero or more, and 0 otherwise.
- R2: `quantIn` is a combinational function of the present `state2` and the present `sampleIn`. It equals round(25390·state2 / 2^14) + round(16384·sampleIn / 2^13).
- R3: On an enabled cycle, `state1` becomes state1 + round(8192·sampleIn / 2^13) − round(8192·f / 2^14). The feedback f is +65536 when the decision of that cycle is 1 and −65536 when it is 0.
- R4: On an enabled cycle, `state2` becomes state2 + round(4574·state1 / 2^14) + round(8192·sampleIn / 2^13) − round(8192·f / 2^14). Here state1 is the value held before the edge.
- R5: Every product is rounded to the state scaling by adding half an LSB and then shifting right arithmetically, so ties go toward plus infinity.
- R6: Each new state is clamped to the range [−SatLimit, +SatLimit] and never wraps. The default SatLimit is 16.0, which is 1048576.
- R7: `overflow` goes high at the edge that ends an enabled cycle in which either state was clamped. It then stays high until reset.
- R8: With `en` low, `state1`, `state2`, `bitOut` and `overflow` keep their values whatever `sampleIn` does.
- R9: A synchronous `rst` clears both states, `bitOut` and `overflow`, and takes priority over `en`.
- R10: For a constant input, the mean of the bipolar bitstream (1 → +1, 0 → −1) over 4096 samples matches the input to within 0.02.
- R11: A sine of amplitude 0.9 of full scale, with the default bound, never clamps a state, so `overflow` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sample enable; the loop advances on cycles where it is high |
| sampleIn | input | 16 | Signed Q1.15 input sample |
| bitOut | output | 1 | Registered one-bit modulator output |
| quantIn | output | 26 | Signed quantizer input, 16 fractional bits |
| state1 | output | 24 | First integrator state, 16 fractional bits |
| state2 | output | 24 | Second integrator state, 16 fractional bits |
| overflow | output | 1 | Sticky flag, high once a state has clipped |

## Verification
The assertions check these on every cycle:
- The states stay inside the clamp bound.
- All state is frozen while `en` is low.
- The registered bit follows the sign of the quantizer input.
- The overflow flag is sticky and is raised after a clip.
- A positive decision with a non-positive input lowers the first state.

Only the bench's scenarios can show the rest:
- The exact rounding of the Q14 coefficient products.
- The bit-true state sequences under DC, sine, gated-enable and full-scale inputs, compared against a behavioural model.
- The DC tracking of the bitstream average.
- The absence of clipping for a 0.9 sine.
- Clamping under a deliberately small bound, using a second instance.

// File: rtl/sdm2_pkg.sv
package sdm2_pkg;

  // Strobes from the control unit to the loop datapath.
  typedef struct packed {
    logic clear;       // synchronous clear of both integrators
    logic advance;     // take one loop step this cycle
    logic fbPositive;  // quantizer decision: feed back +1.0 when high
  } loopStrobe_t;

  // Round half toward +inf, then drop 'shift' fractional bits.
  function automatic logic signed [63:0] roundShift(input logic signed [63:0] prod,
                                                    input int shift);
    logic signed [63:0] half;
    half = 64'sd1 <<< (shift - 1);
    return (prod + half) >>> shift;
  endfunction

endpackage

// File: rtl/sdm2_integrator.sv
module sdm2_integrator
  import sdm2_pkg::*;
#(
  parameter int SW       = 24,
  parameter int SatLimit = 1048576
) (
  input  logic                 clk,
  input  logic                 clear,
  input  logic                 advance,
  input  logic signed [63:0]   delta,
  output logic signed [SW-1:0] state,
  output logic                 clip
);

  localparam logic signed [63:0] LimPos = 64'(SatLimit);
  localparam logic signed [63:0] LimNeg = -64'(SatLimit);

  logic signed [63:0] rawSum;
  logic signed [SW-1:0] nextState;

  always_comb begin
    rawSum = 64'(state) + delta;
    clip   = (rawSum > LimPos) || (rawSum < LimNeg);
    if (rawSum > LimPos)      nextState = SW'(LimPos);
    else if (rawSum < LimNeg) nextState = SW'(LimNeg);
    else                      nextState = SW'(rawSum);
  end

  always_ff @(posedge clk) begin
    if (clear)        state <= '0;
    else if (advance) state <= nextState;
  end

  // R6: state never leaves the clamp window
  a_r6_within_bound: assert property (@(posedge clk) disable iff (clear)
    (64'(state) <= LimPos) && (64'(state) >= LimNeg));

  // R8: no step, no change
  a_r8_hold_state: assert property (@(posedge clk) disable iff (clear)
    !advance |=> $stable(state));

endmodule

// File: rtl/sdm2_datapath.sv
module sdm2_datapath
  import sdm2_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int IN_FRAC   = 15,
  parameter int SW        = 24,
  parameter int SF        = 16,
  parameter int COEF_FRAC = 14,
  parameter int CoefA1    = 8192,
  parameter int CoefA2    = 8192,
  parameter int CoefB1    = 8192,
  parameter int CoefB2    = 8192,
  parameter int CoefB3    = 16384,
  parameter int CoefC1    = 4574,
  parameter int CoefC2    = 25390,
  parameter int SatLimit  = 1048576
) (
  input  logic                   clk,
  input  loopStrobe_t            strb,
  input  logic signed [IN_W-1:0] sampleIn,
  output logic signed [SW+1:0]   quantIn,
  output logic signed [SW-1:0]   state1,
  output logic signed [SW-1:0]   state2,
  output logic                   clipAny
);

  localparam int NumStages = 2;
  localparam int ShiftIn   = IN_FRAC + COEF_FRAC - SF;
  localparam int ShiftSt   = COEF_FRAC;
  localparam int QW        = SW + 2;
  localparam logic signed [63:0] OneState = 64'sd1 <<< SF;

  logic signed [SW-1:0] stateArr [NumStages];
  logic                 clipArr  [NumStages];
  logic signed [63:0]   deltaArr [NumStages];
  logic signed [63:0]   fbVal;
  logic signed [63:0]   inTerm1, inTerm2;

  always_comb begin
    fbVal   = strb.fbPositive ? OneState : -OneState;
    inTerm1 = roundShift(64'(CoefB1) * 64'(sampleIn), ShiftIn);
    inTerm2 = roundShift(64'(CoefB2) * 64'(sampleIn), ShiftIn);
    quantIn = QW'(roundShift(64'(CoefC2) * 64'(stateArr[1]), ShiftSt)
                + roundShift(64'(CoefB3) * 64'(sampleIn), ShiftIn));
    deltaArr[0] = inTerm1 - roundShift(64'(CoefA1) * fbVal, ShiftSt);
    deltaArr[1] = roundShift(64'(CoefC1) * 64'(stateArr[0]), ShiftSt)
                + inTerm2 - roundShift(64'(CoefA2) * fbVal, ShiftSt);
  end

  for (genvar gi = 0; gi < NumStages; gi++) begin : g_stage
    sdm2_integrator #(.SW(SW), .SatLimit(SatLimit)) u_int (
      .clk    (clk),
      .clear  (strb.clear),
      .advance(strb.advance),
      .delta  (deltaArr[gi]),
      .state  (stateArr[gi]),
      .clip   (clipArr[gi])
    );
  end

  assign state1  = stateArr[0];
  assign state2  = stateArr[1];
  assign clipAny = clipArr[0] | clipArr[1];

  // R3: a +1 decision with a non-positive input must pull state1 down (or hold it at the floor)
  a_r3_feedback_sign: assert property (@(posedge clk) disable iff (strb.clear)
    (strb.advance && strb.fbPositive && (sampleIn <= 0))
      |=> (state1 < $past(state1)) || (64'(state1) == -64'(SatLimit)));

endmodule

// File: rtl/sdm2_ctrl.sv
module sdm2_ctrl
  import sdm2_pkg::*;
#(
  parameter int QW = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [QW-1:0] quantIn,
  input  logic                 clipAny,
  output loopStrobe_t          strb,
  output logic                 bitOut,
  output logic                 overflow
);

  logic decision;

  always_comb begin
    decision        = ~quantIn[QW-1];
    strb.clear      = rst;
    strb.advance    = en & ~rst;
    strb.fbPositive = decision;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bitOut   <= 1'b0;
      overflow <= 1'b0;
    end else if (en) begin
      bitOut <= decision;
      if (clipAny) overflow <= 1'b1;
    end
  end

  // R1: emitted bit follows the sign of the quantizer input
  a_r1_bit_sign: assert property (@(posedge clk) disable iff (rst)
    en |=> bitOut == $past(quantIn >= 0));

  // R7: flag is raised after a clip and never drops without reset
  a_r7_raise: assert property (@(posedge clk) disable iff (rst)
    (en && clipAny) |=> overflow);
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R8: bit holds while idle
  a_r8_hold_bit: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(bitOut) && $stable(overflow));

endmodule

// File: rtl/sdm2_modulator.sv
module sdm2_modulator
  import sdm2_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int IN_FRAC   = 15,
  parameter int SW        = 24,
  parameter int SF        = 16,
  parameter int COEF_FRAC = 14,
  parameter int CoefA1    = 8192,
  parameter int CoefA2    = 8192,
  parameter int CoefB1    = 8192,
  parameter int CoefB2    = 8192,
  parameter int CoefB3    = 16384,
  parameter int CoefC1    = 4574,
  parameter int CoefC2    = 25390,
  parameter int SatLimit  = 1048576
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic signed [IN_W-1:0] sampleIn,
  output logic                   bitOut,
  output logic signed [SW+1:0]   quantIn,
  output logic signed [SW-1:0]   state1,
  output logic signed [SW-1:0]   state2,
  output logic                   overflow
);

  localparam int QW = SW + 2;

  loopStrobe_t strb;
  logic        clipAny;

  sdm2_ctrl #(.QW(QW)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .quantIn (quantIn),
    .clipAny (clipAny),
    .strb    (strb),
    .bitOut  (bitOut),
    .overflow(overflow)
  );

  sdm2_datapath #(
    .IN_W(IN_W), .IN_FRAC(IN_FRAC), .SW(SW), .SF(SF), .COEF_FRAC(COEF_FRAC),
    .CoefA1(CoefA1), .CoefA2(CoefA2), .CoefB1(CoefB1), .CoefB2(CoefB2),
    .CoefB3(CoefB3), .CoefC1(CoefC1), .CoefC2(CoefC2), .SatLimit(SatLimit)
  ) u_dp (
    .clk     (clk),
    .strb    (strb),
    .sampleIn(sampleIn),
    .quantIn (quantIn),
    .state1  (state1),
    .state2  (state2),
    .clipAny (clipAny)
  );

endmodule

// File: tb/tb_sdm2_modulator.sv
`timescale 1ns/1ps
module tb_sdm2_modulator;

  logic clk = 1'b0;
  logic rstI = 1'b1;
  logic enI = 1'b0;
  logic signed [15:0] uI = '0;

  logic               bitW  [2];
  logic signed [25:0] qW    [2];
  logic signed [23:0] s1W   [2];
  logic signed [23:0] s2W   [2];
  logic               ovfW  [2];

  int nChecks = 0;
  int nErrors = 0;
  int cycles  = 0;

  longint mx1 [2];
  longint mx2 [2];
  longint mbit[2];
  longint movf[2];
  longint lims[2];

  always #2 clk = ~clk;

  sdm2_modulator dut (
    .clk(clk), .rst(rstI), .en(enI), .sampleIn(uI),
    .bitOut(bitW[0]), .quantIn(qW[0]), .state1(s1W[0]), .state2(s2W[0]), .overflow(ovfW[0]));

  sdm2_modulator #(.SatLimit(16384)) dutClip (
    .clk(clk), .rst(rstI), .en(enI), .sampleIn(uI),
    .bitOut(bitW[1]), .quantIn(qW[1]), .state1(s1W[1]), .state2(s2W[1]), .overflow(ovfW[1]));

  function automatic longint rnd(longint p, int s);
    return (p + (longint'(1) <<< (s - 1))) >>> s;
  endfunction

  function automatic longint clampTo(longint v, longint lim, output bit c);
    c = (v > lim) || (v < -lim);
    if (v > lim) return lim;
    if (v < -lim) return -lim;
    return v;
  endfunction

  function automatic longint qinOf(int k, longint u);
    return rnd(25390 * mx2[k], 14) + rnd(16384 * u, 13);
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep(input bit r, input bit e, input longint u);
    for (int k = 0; k < 2; k++) begin
      if (r) begin
        mx1[k] = 0; mx2[k] = 0; mbit[k] = 0; movf[k] = 0;
      end else if (e) begin
        longint y, f, n1, n2;
        bit c1, c2;
        y  = qinOf(k, u);
        f  = (y >= 0) ? 65536 : -65536;
        n1 = mx1[k] + rnd(8192 * u, 13) - rnd(8192 * f, 14);
        n2 = mx2[k] + rnd(4574 * mx1[k], 14) + rnd(8192 * u, 13) - rnd(8192 * f, 14);
        mx1[k] = clampTo(n1, lims[k], c1);
        mx2[k] = clampTo(n2, lims[k], c2);
        mbit[k] = (y >= 0) ? 1 : 0;
        if (c1 || c2) movf[k] = 1;
      end
    end
  endtask

  // One modulator cycle: drive, check the combinational quantizer input, clock, check state.
  task automatic step(input bit r, input bit e, input int u);
    rstI = r; enI = e; uI = 16'(u);
    @(negedge clk);
    for (int k = 0; k < 2; k++) chk("R2 quantIn", longint'(qW[k]), qinOf(k, u));
    @(posedge clk);
    modelStep(r, e, longint'(u));
    #1;
    for (int k = 0; k < 2; k++) begin
      chk("R1 bitOut", longint'(bitW[k]), mbit[k]);
      chk("R3 state1", longint'(s1W[k]), mx1[k]);
      chk("R4 state2", longint'(s2W[k]), mx2[k]);
      chk("R7 overflow", longint'(ovfW[k]), movf[k]);
    end
    chk("R6 clip bound", longint'((s1W[1] <= 16384) && (s1W[1] >= -16384)
                                 && (s2W[1] <= 16384) && (s2W[1] >= -16384)), 1);
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    nErrors++;
    $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin : stim
    lims[0] = 1048576; lims[1] = 16384;
    for (int k = 0; k < 2; k++) begin
      mx1[k] = 0; mx2[k] = 0; mbit[k] = 0; movf[k] = 0;
    end

    // R9 reset state
    repeat (3) step(1, 0, 0);
    chk("R9 reset bit", longint'(bitW[0]), 0);
    chk("R9 reset state1", longint'(s1W[0]), 0);
    chk("R9 reset overflow", longint'(ovfW[0]), 0);

    // R5 rounding: one step with u=1 then look at quantIn
    step(0, 1, 1);
    chk("R3 after first step", longint'(s1W[0]), -32767);
    chk("R4 after first step", longint'(s2W[0]), -32767);
    rstI = 1'b0; enI = 1'b0; uI = '0;
    @(negedge clk);
    chk("R5 rounded c2 product", longint'(qW[0]), -50778);
    @(posedge clk); #1;

    // R10 DC tracking
    step(1, 1, 0);
    begin
      longint acc = 0;
      repeat (4096) begin
        step(0, 1, 16384);
        acc += bitW[0] ? 1 : -1;
      end
      chk("R10 dc mean in range",
          longint'((acc >= 1966) && (acc <= 2130)), 1);
    end

    // R11 sine at 0.9 full scale, default bound
    step(1, 0, 0);
    for (int n = 0; n < 4096; n++)
      step(0, 1, $rtoi(0.9 * 32767.0 * $sin(6.283185307 * n / 64.0)));
    chk("R11 no clip for 0.9 sine", longint'(ovfW[0]), 0);
    chk("R7 small bound clipped", longint'(ovfW[1]), 1);

    // R8 idle hold with moving input
    begin
      longint h1, h2, hb;
      h1 = s1W[0]; h2 = s2W[0]; hb = bitW[0];
      for (int n = 0; n < 6; n++) step(0, 0, 5000 * n - 12000);
      chk("R8 state1 held", longint'(s1W[0]), h1);
      chk("R8 state2 held", longint'(s2W[0]), h2);
      chk("R8 bit held", longint'(bitW[0]), hb);
      chk("R8 flag held", longint'(ovfW[1]), 1);
    end

    // gated enable with a pseudo-random input
    begin
      int lfsr = 12345;
      for (int n = 0; n < 2000; n++) begin
        lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
        step(0, (n % 3) != 0, ((lfsr >>> 8) % 52000) - 26000);
      end
    end

    // full-scale extremes
    repeat (300) step(0, 1, 32767);
    repeat (300) step(0, 1, -32768);

    // R9 reset wins over enable
    step(1, 1, 32767);
    chk("R9 reset over enable state1", longint'(s1W[0]), 0);
    chk("R9 reset over enable flag", longint'(ovfW[1]), 0);
    chk("R9 reset over enable bit", longint'(bitW[1]), 0);

    $display("  CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

endmodule